// File: doc/BRIEF.md
# Page-Mode DRAM Controller with Line Bursts

This block connects a 32-bit processor local bus to fast page mode DRAM. It claims a fixed 256 MB window of the local address space. Whatever memory is installed (4 to 64 MB) repeats across the whole window, so any access inside the window completes. It never ends with a bus error because of its address. A request is either a single long-word read or write, or a four-beat read that fills one cache line. The burst opens the row once and then issues only column strobes, so beats after the first cost half as many cycles.

Even byte parity is generated for every lane that is written. It is checked on all four lanes of every read. When parity checking is enabled, a failing read beat is terminated with a bus error. A refresh timer requests CAS-before-RAS refresh cycles. The controller serves these only while it is idle between bus cycles. The installed size is set on a configuration input and reported back in megabytes through a status register.

Requests use a valid/ready handshake. A request transfers on a clock edge where both `req_valid` and `req_ready` are high. `req_ready` is high only while the controller is idle with no refresh pending. A requester that sees `req_ready` low must hold its request stable. Responses carry no back-pressure: each `rsp_valid` pulse lasts one cycle, and the receiver must take it in that cycle.

Top module: `dram_burst_ctrl`

## Requirements
- R1: A request with address bits [31:28] equal to 4'h2 starts a DRAM cycle. A request outside that window is accepted with no response and no row strobe.
- R2: The size code `cfg_size` selects 4/8/16/32/64 MB for codes 0/1/2/3/4, and codes above 4 act as 4. The long-word address addr[25:2] is masked to 20+code bits. The row is masked bits [23:12] and the column is masked bits [11:0].
- R3: `stat_size_mb` shows the installed size in megabytes (4 << code), one clock after `cfg_size` changes. After reset it reflects the current code.
- R4: A single access returns `rsp_valid` with `rsp_last` in the fourth cycle after the acceptance edge. The row is then closed. `req_ready` returns two cycles after the response, once RAS precharge is done.
- R5: A burst read returns four beats, in cycles 4, 6, 8 and 10 after acceptance. `rsp_last` is set only on the fourth beat.
- R6: Burst beats step through the aligned four-word line, starting at the requested word and taking column bits [1:0] modulo 4.
- R7: A write (always single) asserts only the CAS lines of lanes whose `req_be` bit is 1, with `dram_we_n` low and `dram_dq_oe` high. Each `dram_par_out` bit equals the XOR of its byte (even parity).
- R8: When `cfg_par_en` is 1, a read beat whose lane fails even parity (XOR of byte and parity bit is 1) returns `rsp_berr`=1. When it is 0, reads acknowledge normally.
- R9: A nonzero `cfg_ref_div` requests one CAS-before-RAS refresh every `cfg_ref_div` cycles, and zero disables refresh. A refresh is served only when idle, never within a burst.
- R10: A bus-error beat ends a burst: it carries `rsp_last`, and no further beats follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_addr | input | 32 | Byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | Four-beat line read (ignored for writes) |
| req_be | input | 4 | Byte lane enables for writes |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle response/beat strobe |
| rsp_data | output | 32 | Read data of the beat |
| rsp_berr | output | 1 | Bus-error termination |
| rsp_last | output | 1 | Final beat of the access |
| cfg_size | input | 3 | Installed size code |
| cfg_par_en | input | 1 | Parity checking enable |
| cfg_ref_div | input | 16 | Refresh interval in cycles, 0 = off |
| stat_size_mb | output | 7 | Installed size in MB |
| dram_addr | output | 12 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 4 | Per-lane column strobes, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_oe | output | 1 | Data bus drive enable |
| dram_dq_out | output | 32 | Write data to DRAM |
| dram_par_out | output | 4 | Parity bits to DRAM |
| dram_dq_in | input | 32 | Read data from DRAM |
| dram_par_in | input | 4 | Parity bits from DRAM |

## Verification
Take the accepting edge as cycle 0. The row strobe falls in cycle 1, the first column strobe comes in cycle 3, and the first beat is seen in cycle 4. Burst beats then follow in cycles 6, 8 and 10. After a single access `req_ready` comes back in cycle 6, and after a burst in cycle 12. The status output follows its configuration one cycle later. Each task drives on a falling edge and counts falling edges from the acceptance edge. It records which count every beat, strobe and ready level appears on, and compares those counts with the cycle numbers above.

// File: rtl/dram_pkg.sv
package dram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_CPRE,
    ST_CACT,
    ST_PRECH,
    ST_RFC,
    ST_RFR
  } dram_st_t;

  function automatic logic [2:0] size_clamp(input logic [2:0] code);
    return (code > 3'd4) ? 3'd4 : code;
  endfunction

  function automatic logic [6:0] size_mb(input logic [2:0] code);
    return 7'd4 << size_clamp(code);
  endfunction

endpackage

// File: rtl/dram_addr_map.sv
module dram_addr_map #(
  parameter int          ROW_W    = 12,
  parameter int          COL_W    = 12,
  parameter int          MIN_BITS = 20,
  parameter logic [3:0]  WIN_BASE = 4'h2
) (
  input  logic [31:0]       addr,
  input  logic [2:0]        size_code,
  output logic              hit,
  output logic [ROW_W-1:0]  row,
  output logic [COL_W-1:0]  col
);
  localparam int WA_W = ROW_W + COL_W;

  logic [WA_W-1:0] mask;
  logic [WA_W-1:0] wa;
  int              nbits;
  logic            unused_bits;

  always_comb begin
    nbits = MIN_BITS + int'(dram_pkg::size_clamp(size_code));
    for (int i = 0; i < WA_W; i++) begin
      mask[i] = (i < nbits);
    end
  end

  assign wa          = addr[WA_W+1:2] & mask;
  assign row         = wa[WA_W-1:COL_W];
  assign col         = wa[COL_W-1:0];
  assign hit         = (addr[31:28] == WIN_BASE);
  assign unused_bits = ^{addr[27:WA_W+2], addr[1:0]};
endmodule

// File: rtl/dram_parity.sv
module dram_parity #(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8
) (
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] rdata,
  input  logic [LANES-1:0]  rpar,
  output logic [LANES-1:0]  wpar,
  output logic [LANES-1:0]  lane_err
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign wpar[g]     = ^wdata[g*8 +: 8];
    assign lane_err[g] = (^rdata[g*8 +: 8]) ^ rpar[g];
  end
endmodule

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] div,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || div == '0) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (cnt_q >= div - 1'b1) begin
      cnt_q <= '0;
      tick  <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      tick  <= 1'b0;
    end
  end
endmodule

// File: rtl/dram_burst_ctrl.sv
module dram_burst_ctrl #(
  parameter int DATA_W  = 32,
  parameter int ROW_W   = 12,
  parameter int COL_W   = 12,
  parameter int RP_CYC  = 2,
  parameter int RFC_CYC = 2,
  parameter int REF_W   = 16,
  localparam int LANES  = DATA_W / 8,
  localparam int MA_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_addr,
  input  logic              req_write,
  input  logic              req_burst,
  input  logic [LANES-1:0]  req_be,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_berr,
  output logic              rsp_last,
  input  logic [2:0]        cfg_size,
  input  logic              cfg_par_en,
  input  logic [REF_W-1:0]  cfg_ref_div,
  output logic [6:0]        stat_size_mb,
  output logic [MA_W-1:0]   dram_addr,
  output logic              dram_ras_n,
  output logic [LANES-1:0]  dram_cas_n,
  output logic              dram_we_n,
  output logic              dram_dq_oe,
  output logic [DATA_W-1:0] dram_dq_out,
  output logic [LANES-1:0]  dram_par_out,
  input  logic [DATA_W-1:0] dram_dq_in,
  input  logic [LANES-1:0]  dram_par_in
);
  import dram_pkg::*;

  localparam int TMAX = (RP_CYC > RFC_CYC) ? RP_CYC : RFC_CYC;
  localparam int TW   = $clog2(TMAX + 1);

  dram_st_t           st_q;
  logic [ROW_W-1:0]   row_q;
  logic [COL_W-1:0]   col_q;
  logic [COL_W-1:0]   col_cur;
  logic [1:0]         beat_q;
  logic               burst_q;
  logic               write_q;
  logic [LANES-1:0]   be_q;
  logic [DATA_W-1:0]  wdata_q;
  logic [TW-1:0]      tmr_q;
  logic               ref_pend_q;

  logic               map_hit;
  logic [ROW_W-1:0]   map_row;
  logic [COL_W-1:0]   map_col;
  logic [LANES-1:0]   lane_err;
  logic               ref_tick;
  logic               beat_err;
  logic               beat_last;
  logic               col_phase;

  dram_addr_map #(.ROW_W(ROW_W), .COL_W(COL_W)) u_map (
    .addr      (req_addr),
    .size_code (cfg_size),
    .hit       (map_hit),
    .row       (map_row),
    .col       (map_col)
  );

  dram_parity #(.DATA_W(DATA_W)) u_par (
    .wdata    (wdata_q),
    .rdata    (dram_dq_in),
    .rpar     (dram_par_in),
    .wpar     (dram_par_out),
    .lane_err (lane_err)
  );

  dram_refresh_timer #(.CNT_W(REF_W)) u_ref (
    .clk   (clk),
    .rst_n (rst_n),
    .div   (cfg_ref_div),
    .tick  (ref_tick)
  );

  assign col_cur   = {col_q[COL_W-1:2], col_q[1:0] + beat_q};
  assign col_phase = (st_q == ST_CPRE) || (st_q == ST_CACT);
  assign beat_err  = !write_q && cfg_par_en && (|lane_err);
  assign beat_last = !burst_q || (beat_q == 2'd3) || beat_err;
  assign req_ready = (st_q == ST_IDLE) && !ref_pend_q;

  // DRAM pin decode from state
  always_comb begin
    dram_ras_n  = !((st_q == ST_ROW) || col_phase || (st_q == ST_RFR));
    dram_we_n   = !(write_q && col_phase);
    dram_dq_oe  = write_q && col_phase;
    dram_dq_out = wdata_q;
    case (st_q)
      ST_CACT:        dram_cas_n = write_q ? ~be_q : '0;
      ST_RFC, ST_RFR: dram_cas_n = '0;
      default:        dram_cas_n = '1;
    endcase
    case (st_q)
      ST_ROW:           dram_addr = MA_W'(row_q);
      ST_CPRE, ST_CACT: dram_addr = MA_W'(col_cur);
      default:          dram_addr = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stat_size_mb <= 7'd0;
    else        stat_size_mb <= size_mb(cfg_size);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      row_q      <= '0;
      col_q      <= '0;
      beat_q     <= '0;
      burst_q    <= 1'b0;
      write_q    <= 1'b0;
      be_q       <= '0;
      wdata_q    <= '0;
      tmr_q      <= '0;
      ref_pend_q <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
      rsp_berr   <= 1'b0;
      rsp_last   <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (ref_tick) ref_pend_q <= 1'b1;
      else if (st_q == ST_IDLE && ref_pend_q) ref_pend_q <= 1'b0;

      case (st_q)
        ST_IDLE: begin
          if (ref_pend_q) begin
            st_q <= ST_RFC;
          end else if (req_valid && map_hit) begin
            st_q    <= ST_ROW;
            row_q   <= map_row;
            col_q   <= map_col;
            beat_q  <= '0;
            burst_q <= req_burst && !req_write;
            write_q <= req_write;
            be_q    <= req_be;
            wdata_q <= req_wdata;
          end
        end
        ST_ROW:  st_q <= ST_CPRE;
        ST_CPRE: st_q <= ST_CACT;
        ST_CACT: begin
          rsp_valid <= 1'b1;
          rsp_data  <= write_q ? '0 : dram_dq_in;
          rsp_berr  <= beat_err;
          rsp_last  <= beat_last;
          if (beat_last) begin
            st_q  <= ST_PRECH;
            tmr_q <= TW'(RP_CYC - 1);
          end else begin
            beat_q <= beat_q + 2'd1;
            st_q   <= ST_CPRE;
          end
        end
        ST_PRECH: begin
          if (tmr_q == '0) st_q <= ST_IDLE;
          else             tmr_q <= tmr_q - 1'b1;
        end
        ST_RFC: begin
          st_q  <= ST_RFR;
          tmr_q <= TW'(RFC_CYC - 1);
        end
        ST_RFR: begin
          if (tmr_q == '0) begin
            st_q  <= ST_PRECH;
            tmr_q <= TW'(RP_CYC - 1);
          end else begin
            tmr_q <= tmr_q - 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dram_burst_ctrl_chk.sv
module dram_burst_ctrl_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_berr,
  input logic             rsp_last,
  input logic             cfg_par_en,
  input logic             dram_ras_n,
  input logic [LANES-1:0] dram_cas_n,
  input logic             dram_we_n,
  input logic             dram_dq_oe
);
  AST_READY_ROW_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (dram_ras_n && dram_cas_n == '1));                        // R4
  AST_BEAT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);                                               // R5
  AST_NO_BERR_PAR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !cfg_par_en) |-> !rsp_berr);                               // R8
  AST_BERR_ENDS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_berr) |-> rsp_last);                                   // R10
  AST_WE_DRIVES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_we_n |-> dram_dq_oe);                                              // R7
  AST_REFRESH_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (dram_ras_n && dram_cas_n == '0) |-> (dram_we_n && !req_ready));         // R9
endmodule

bind dram_burst_ctrl dram_burst_ctrl_chk #(.LANES(LANES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .rsp_berr   (rsp_berr),
  .rsp_last   (rsp_last),
  .cfg_par_en (cfg_par_en),
  .dram_ras_n (dram_ras_n),
  .dram_cas_n (dram_cas_n),
  .dram_we_n  (dram_we_n),
  .dram_dq_oe (dram_dq_oe)
);

// File: tb/tb_dram_burst_ctrl.sv
module tb_dram_burst_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        req_burst = 1'b0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        rsp_berr;
  logic        rsp_last;
  logic [2:0]  cfg_size = 3'd4;
  logic        cfg_par_en = 1'b1;
  logic [15:0] cfg_ref_div = '0;
  logic [6:0]  stat_size_mb;
  logic [11:0] dram_addr;
  logic        dram_ras_n;
  logic [3:0]  dram_cas_n;
  logic        dram_we_n;
  logic        dram_dq_oe;
  logic [31:0] dram_dq_out;
  logic [3:0]  dram_par_out;
  logic [31:0] dram_dq_in;
  logic [3:0]  dram_par_in;

  always #10 clk = ~clk;

  dram_burst_ctrl dut (.*);

  // DRAM model: data is a function of row and column
  logic [11:0] row_l = '0;
  logic        ras_prev = 1'b1;
  logic        corrupt_en = 1'b0;
  logic [11:0] corrupt_col = '0;
  int          ref_cnt = 0;

  assign dram_dq_in = {row_l, dram_addr, 8'h5A};
  always_comb begin
    for (int l = 0; l < 4; l++) dram_par_in[l] = ^dram_dq_in[l*8 +: 8];
    if (corrupt_en && dram_addr == corrupt_col) dram_par_in[1] = ~dram_par_in[1];
  end

  always @(negedge clk) begin
    if (ras_prev && !dram_ras_n) row_l <= dram_addr;
    ras_prev <= dram_ras_n;
    if (rst_n && dram_ras_n && dram_cas_n == 4'h0) ref_cnt <= ref_cnt + 1;
  end

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_data(input logic [31:0] a, input logic [2:0] code, input int k);
    logic [23:0] wa;
    logic [11:0] c;
    wa = a[25:2] & 24'((32'd1 << (20 + int'(code))) - 1);
    c  = {wa[11:2], wa[1:0] + 2'(k)};
    return {wa[23:12], c, 8'h5A};
  endfunction

  // results of the last access
  int          nbeats, ready_idx, ras_low_cnt;
  int          b_idx [4];
  logic [31:0] b_data [4];
  logic        b_berr [4], b_last [4];
  logic [11:0] row_at1;
  logic [3:0]  cas3;
  logic        we3, oe3;
  logic [31:0] dq3;
  logic [3:0]  par3;
  int          ref_before;

  task automatic run_req(input logic [31:0] a, input logic wr, input logic bu,
                         input logic [3:0] be, input logic [31:0] wd);
    for (int g = 0; g < 100 && !req_ready; g++) @(negedge clk);
    req_addr = a; req_write = wr; req_burst = bu; req_be = be; req_wdata = wd;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    nbeats = 0; ready_idx = -1; ras_low_cnt = 0; ref_before = ref_cnt;
    for (int i = 1; i <= 14; i++) begin
      if (i > 1) @(negedge clk);
      if (i == 1) row_at1 = dram_addr;
      if (i == 3) begin
        cas3 = dram_cas_n; we3 = dram_we_n; oe3 = dram_dq_oe; dq3 = dram_dq_out; par3 = dram_par_out;
      end
      if (!dram_ras_n) ras_low_cnt++;
      if (rsp_valid && nbeats < 4) begin
        b_idx[nbeats] = i; b_data[nbeats] = rsp_data;
        b_berr[nbeats] = rsp_berr; b_last[nbeats] = rsp_last;
        nbeats++;
      end
      if (req_ready && ready_idx < 0) ready_idx = i;
    end
  endtask

  task automatic t_reset;
    chk(req_ready == 1'b1, "R4 ready after reset", 32'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R4 no response after reset", 32'(rsp_valid), 0);
    chk(dram_ras_n && dram_cas_n == 4'hF, "R4 strobes idle", {27'd0, dram_ras_n, dram_cas_n}, 32'h1F);
    chk(stat_size_mb == 7'd64, "R3 status after reset", 32'(stat_size_mb), 64);
  endtask

  task automatic t_status;
    cfg_size = 3'd1;
    @(negedge clk);
    chk(stat_size_mb == 7'd8, "R3 status 8MB", 32'(stat_size_mb), 8);
    cfg_size = 3'd6;
    @(negedge clk);
    chk(stat_size_mb == 7'd64, "R3 status clamp", 32'(stat_size_mb), 64);
    cfg_size = 3'd4;
    @(negedge clk);
  endtask

  task automatic t_single;
    logic [31:0] a = 32'h2012_3458;
    run_req(a, 1'b0, 1'b0, 4'hF, '0);
    chk(nbeats == 1, "R4 single beat count", 32'(nbeats), 1);
    chk(b_idx[0] == 4, "R4 single beat cycle", 32'(b_idx[0]), 4);
    chk(b_data[0] == exp_data(a, 3'd4, 0), "R4 single data", b_data[0], exp_data(a, 3'd4, 0));
    chk(b_last[0] && !b_berr[0], "R4 single last/no berr", {30'd0, b_last[0], b_berr[0]}, 2);
    chk(ready_idx == 6, "R4 ready after precharge", 32'(ready_idx), 6);
    chk(ras_low_cnt == 3, "R4 row open cycles", 32'(ras_low_cnt), 3);
  endtask

  task automatic t_burst;
    logic [31:0] a = 32'h2000_1008;
    run_req(a, 1'b0, 1'b1, 4'hF, '0);
    chk(nbeats == 4, "R5 burst beat count", 32'(nbeats), 4);
    for (int k = 0; k < 4; k++) begin
      chk(b_idx[k] == 4 + 2 * k, "R5 beat cycle", 32'(b_idx[k]), 32'(4 + 2 * k));
      chk(b_data[k] == exp_data(a, 3'd4, k), "R6 wrap order data", b_data[k], exp_data(a, 3'd4, k));
      chk(b_last[k] == (k == 3), "R5 last flag", 32'(b_last[k]), 32'(k == 3));
    end
    chk(ready_idx == 12, "R5 ready after burst", 32'(ready_idx), 12);
  endtask

  task automatic t_alias;
    logic [31:0] a = 32'h2FFF_FFF8;
    cfg_size = 3'd0;
    run_req(a, 1'b0, 1'b0, 4'hF, '0);
    chk(row_at1 == 12'h0FF, "R2 row 4MB alias", 32'(row_at1), 32'h0FF);
    chk(b_data[0] == exp_data(a, 3'd0, 0) && !b_berr[0], "R2 data 4MB alias", b_data[0], exp_data(a, 3'd0, 0));
    cfg_size = 3'd2;
    run_req(a, 1'b0, 1'b0, 4'hF, '0);
    chk(row_at1 == 12'h3FF, "R2 row 16MB alias", 32'(row_at1), 32'h3FF);
    chk(b_data[0] == exp_data(a, 3'd2, 0), "R2 data 16MB alias", b_data[0], exp_data(a, 3'd2, 0));
    cfg_size = 3'd4;
  endtask

  task automatic t_write;
    logic [31:0] wd = 32'h1234_80FF;
    logic [3:0]  ep;
    for (int l = 0; l < 4; l++) ep[l] = ^wd[l*8 +: 8];
    run_req(32'h2000_0040, 1'b1, 1'b1, 4'b0101, wd);
    chk(cas3 == 4'b1010, "R7 lane CAS", 32'(cas3), 32'hA);
    chk(!we3 && oe3, "R7 we/oe", {30'd0, we3, oe3}, 1);
    chk(dq3 == wd, "R7 write data", dq3, wd);
    chk(par3 == ep, "R7 parity out", 32'(par3), 32'(ep));
    chk(nbeats == 1 && b_idx[0] == 4 && !b_berr[0], "R7 write ack single", 32'(nbeats), 1);
  endtask

  task automatic t_parity;
    logic [31:0] a = 32'h2000_2004;
    corrupt_en = 1'b1;
    corrupt_col = {10'h200, 2'd3};
    run_req(a, 1'b0, 1'b1, 4'hF, '0);
    chk(nbeats == 3, "R10 burst ended on error", 32'(nbeats), 3);
    chk(!b_berr[1] && b_berr[2], "R8 berr on bad beat", {30'd0, b_berr[1], b_berr[2]}, 1);
    chk(b_last[2] && b_idx[2] == 8, "R10 last on error beat", 32'(b_idx[2]), 8);
    cfg_par_en = 1'b0;
    run_req(a, 1'b0, 1'b1, 4'hF, '0);
    chk(nbeats == 4 && !b_berr[2] && !b_berr[3], "R8 check disabled", 32'(nbeats), 4);
    cfg_par_en = 1'b1;
    corrupt_en = 1'b0;
  endtask

  task automatic t_window;
    run_req(32'h3000_0000, 1'b0, 1'b0, 4'hF, '0);
    chk(nbeats == 0 && ras_low_cnt == 0, "R1 above window ignored", 32'(ras_low_cnt), 0);
    chk(ready_idx == 1, "R1 ready stays high", 32'(ready_idx), 1);
    run_req(32'h1FFF_FFFC, 1'b0, 1'b0, 4'hF, '0);
    chk(nbeats == 0 && ras_low_cnt == 0, "R1 below window ignored", 32'(nbeats), 0);
    run_req(32'h2FFF_FFFC, 1'b0, 1'b0, 4'hF, '0);
    chk(nbeats == 1 && !b_berr[0], "R1 top of window served", 32'(nbeats), 1);
  endtask

  task automatic t_refresh;
    int r0;
    cfg_ref_div = 16'd40;
    r0 = ref_cnt;
    repeat (400) @(negedge clk);
    chk(ref_cnt - r0 >= 9 && ref_cnt - r0 <= 10, "R9 refresh rate", 32'(ref_cnt - r0), 10);
    cfg_ref_div = 16'd10;
    run_req(32'h2000_3000, 1'b0, 1'b1, 4'hF, '0);
    chk(nbeats == 4 && b_idx[3] == 10, "R9 burst not split", 32'(b_idx[3]), 10);
    chk(ref_cnt - ref_before <= 1, "R9 refresh deferred", 32'(ref_cnt - ref_before), 1);
    cfg_ref_div = 16'd0;
    repeat (20) @(negedge clk);
    r0 = ref_cnt;
    repeat (60) @(negedge clk);
    chk(ref_cnt == r0, "R9 refresh off", 32'(ref_cnt - r0), 0);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_status;
    t_single;
    t_burst;
    t_alias;
    t_write;
    t_parity;
    t_window;
    t_refresh;
    finish_run;
  end

  initial begin
    #(20 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    finish_run;
  end
endmodule